// File: doc/BRIEF.md
# Serial Audio Port Routing Matrix

This block is a routing fabric that ties several serial audio ports together. Some ports are host ports and the rest are peripheral ports. Each port is modelled as a pin group with six signals: a transmit clock and a transmit frame sync, a receive clock and a receive frame sync, an inbound data pin ("din", the data the attached device sends) and an outbound data pin ("dout", the routed data delivered to the device). Every pin has an input value, an output value and an output enable, so the pad cells outside can be wired directly.

Each port has one configuration register. It selects the source port and the direction of each clock and frame sync, and whether receive timing is shared with transmit timing or kept separate. It also selects where the port's received data comes from, and whether the two data pins swap roles so that the port can change between master and slave without rewiring. On a host port, a network mode can replace the single data source with the AND of the data from every port that is not excluded in a mask. This serves time-slotted links, where idle talkers hold the line high. The routing path has no registers. Only the configuration registers are clocked.

Top module: `audio_route_matrix`

## Requirements
- R1: After reset every configuration register reads 0. All clock and frame-sync enables are 0, every dout pin is enabled, and every dout pin carries the data contributed by port 0.
- R2: A write with `cfg_we` high and `cfg_addr` below the port count is stored at the next rising clock edge. The old value still reads back before that edge. Bits 31:24 read as 0. Addresses at or above the port count read 0, and writes to them change nothing.
- R3: Register layout for the transmit side: bits 2:0 are the transmit source port, bit 3 enables the transmit clock output and bit 4 enables the transmit frame-sync output. When an enable bit is 1, the output carries the source port's input pin and its output enable is 1. When it is 0, the output enable and the output are both 0 and the source is ignored.
- R4: Bit 13 (shared timing) makes the receive clock and the receive frame sync copy the transmit clock and transmit frame sync, both value and enable.
- R5: With bit 13 clear, the receive clock and receive frame sync take their source from bits 7:5 and their enables from bit 8 (clock) and bit 9 (frame sync).
- R6: Bits 12:10 select the port whose contributed data is received. Values 0 to 2 are host ports and values 3 to 5 are peripheral ports. Values 6 and 7 deliver a constant 1.
- R7: A port's contributed data is its din input. When bit 14 (pin swap) is set, the din pin becomes an output carrying the received data and the dout pin becomes an input (enable 0, value 0). The port's contributed data is then taken from its dout input.
- R8: On a host port, bit 15 (network mode) makes the received data the AND of the contributions of every port whose bit in the mask at bits 23:16 is 0. Mask bits for nonexistent ports are ignored. If every port is excluded, the result is 1.
- R9: Network mode set on a peripheral port has no effect, and with network mode clear the mask is ignored.
- R10: Routed outputs follow input pins within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (port number) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed register |
| tck_i | input | 6 | Transmit clock pin inputs, one per port |
| tck_o | output | 6 | Transmit clock pin outputs |
| tck_oe | output | 6 | Transmit clock output enables |
| tfs_i | input | 6 | Transmit frame-sync pin inputs |
| tfs_o | output | 6 | Transmit frame-sync pin outputs |
| tfs_oe | output | 6 | Transmit frame-sync output enables |
| rck_i | input | 6 | Receive clock pin inputs |
| rck_o | output | 6 | Receive clock pin outputs |
| rck_oe | output | 6 | Receive clock output enables |
| rfs_i | input | 6 | Receive frame-sync pin inputs |
| rfs_o | output | 6 | Receive frame-sync pin outputs |
| rfs_oe | output | 6 | Receive frame-sync output enables |
| din_i | input | 6 | Inbound data pin inputs |
| din_o | output | 6 | Inbound data pin outputs (driven only when swapped) |
| din_oe | output | 6 | Inbound data pin output enables |
| dout_i | input | 6 | Outbound data pin inputs (used only when swapped) |
| dout_o | output | 6 | Outbound data pin outputs |
| dout_oe | output | 6 | Outbound data pin output enables |

## Verification
The bench uses the default parameters: six ports, three of which are hosts, and a 3-bit address. With these values the two unused addresses and the two unused select codes (6 and 7) can be reached, along with mask bits 6 and 7, which lie above the port count. Host and peripheral ports both exist, so network mode can be tried on a port where it must work and on one where it must be ignored. Pin inputs are randomised every cycle while each configuration is applied.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;
    localparam int SELW  = 3;
    localparam int MASKW = 8;
    localparam int CFG_W = 24;
    localparam int BUS_W = 32;

    typedef struct packed {
        logic [MASKW-1:0] mask;     // 23:16
        logic             net_en;   // 15
        logic             swap;     // 14
        logic             sync;     // 13
        logic [SELW-1:0]  dsel;     // 12:10
        logic             rfs_out;  // 9
        logic             rck_out;  // 8
        logic [SELW-1:0]  rsel;     // 7:5
        logic             tfs_out;  // 4
        logic             tck_out;  // 3
        logic [SELW-1:0]  tsel;     // 2:0
    } port_cfg_t;
endpackage

// File: rtl/audio_route_cfg.sv
module audio_route_cfg
    import audio_route_pkg::*;
#(
    parameter int NPORT = 6,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [BUS_W-1:0] cfg_wdata,
    output logic [BUS_W-1:0] cfg_rdata,
    output port_cfg_t        cfg_q [NPORT]
);
    port_cfg_t cfg_d [NPORT];

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && (32'(cfg_addr) < NPORT)) begin
            cfg_d[cfg_addr] = port_cfg_t'(cfg_wdata[CFG_W-1:0]);
        end
        cfg_rdata = '0;
        if (32'(cfg_addr) < NPORT) begin
            cfg_rdata[CFG_W-1:0] = cfg_q[cfg_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPORT; i++) cfg_q[i] <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/audio_route_port.sv
module audio_route_port
    import audio_route_pkg::*;
#(
    parameter int NPORT   = 6,
    parameter bit IS_HOST = 1'b1
) (
    input  port_cfg_t        cfg,
    input  logic [NPORT-1:0] tck_all,
    input  logic [NPORT-1:0] tfs_all,
    input  logic [NPORT-1:0] rck_all,
    input  logic [NPORT-1:0] rfs_all,
    input  logic [NPORT-1:0] data_all,
    output logic             tck_o,
    output logic             tck_oe,
    output logic             tfs_o,
    output logic             tfs_oe,
    output logic             rck_o,
    output logic             rck_oe,
    output logic             rfs_o,
    output logic             rfs_oe,
    output logic             din_o,
    output logic             din_oe,
    output logic             dout_o,
    output logic             dout_oe
);
    localparam int NSRC = 1 << SELW;

    typedef struct packed {
        logic tck, tck_oe, tfs, tfs_oe;
        logic rck, rck_oe, rfs, rfs_oe;
        logic din, din_oe, dout, dout_oe;
    } pins_t;

    logic [NSRC-1:0] pad_tck, pad_tfs, pad_rck, pad_rfs, pad_dat;
    pins_t pins_d;
    logic  net_and, recv;

    // selects past the last port see the idle level
    for (genvar i = 0; i < NSRC; i++) begin : g_pad
        if (i < NPORT) begin : g_real
            assign pad_tck[i] = tck_all[i];
            assign pad_tfs[i] = tfs_all[i];
            assign pad_rck[i] = rck_all[i];
            assign pad_rfs[i] = rfs_all[i];
            assign pad_dat[i] = data_all[i];
        end else begin : g_idle
            assign pad_tck[i] = 1'b1;
            assign pad_tfs[i] = 1'b1;
            assign pad_rck[i] = 1'b1;
            assign pad_rfs[i] = 1'b1;
            assign pad_dat[i] = 1'b1;
        end
    end

    always_comb begin
        net_and = 1'b1;
        for (int j = 0; j < NPORT; j++) begin
            if (!cfg.mask[j]) net_and = net_and & data_all[j];
        end
        recv = (IS_HOST && cfg.net_en) ? net_and : pad_dat[cfg.dsel];

        pins_d        = '0;
        pins_d.tck_oe = cfg.tck_out;
        pins_d.tck    = cfg.tck_out & pad_tck[cfg.tsel];
        pins_d.tfs_oe = cfg.tfs_out;
        pins_d.tfs    = cfg.tfs_out & pad_tfs[cfg.tsel];
        if (cfg.sync) begin
            pins_d.rck_oe = pins_d.tck_oe;
            pins_d.rck    = pins_d.tck;
            pins_d.rfs_oe = pins_d.tfs_oe;
            pins_d.rfs    = pins_d.tfs;
        end else begin
            pins_d.rck_oe = cfg.rck_out;
            pins_d.rck    = cfg.rck_out & pad_rck[cfg.rsel];
            pins_d.rfs_oe = cfg.rfs_out;
            pins_d.rfs    = cfg.rfs_out & pad_rfs[cfg.rsel];
        end
        pins_d.din_oe  = cfg.swap;
        pins_d.din     = cfg.swap & recv;
        pins_d.dout_oe = !cfg.swap;
        pins_d.dout    = !cfg.swap & recv;
    end

    assign tck_o   = pins_d.tck;
    assign tck_oe  = pins_d.tck_oe;
    assign tfs_o   = pins_d.tfs;
    assign tfs_oe  = pins_d.tfs_oe;
    assign rck_o   = pins_d.rck;
    assign rck_oe  = pins_d.rck_oe;
    assign rfs_o   = pins_d.rfs;
    assign rfs_oe  = pins_d.rfs_oe;
    assign din_o   = pins_d.din;
    assign din_oe  = pins_d.din_oe;
    assign dout_o  = pins_d.dout;
    assign dout_oe = pins_d.dout_oe;
endmodule

// File: rtl/audio_route_matrix.sv
module audio_route_matrix
    import audio_route_pkg::*;
#(
    parameter int NPORT = 6,
    parameter int NHOST = 3,
    localparam int AW   = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [BUS_W-1:0] cfg_wdata,
    output logic [BUS_W-1:0] cfg_rdata,
    input  logic [NPORT-1:0] tck_i,
    output logic [NPORT-1:0] tck_o,
    output logic [NPORT-1:0] tck_oe,
    input  logic [NPORT-1:0] tfs_i,
    output logic [NPORT-1:0] tfs_o,
    output logic [NPORT-1:0] tfs_oe,
    input  logic [NPORT-1:0] rck_i,
    output logic [NPORT-1:0] rck_o,
    output logic [NPORT-1:0] rck_oe,
    input  logic [NPORT-1:0] rfs_i,
    output logic [NPORT-1:0] rfs_o,
    output logic [NPORT-1:0] rfs_oe,
    input  logic [NPORT-1:0] din_i,
    output logic [NPORT-1:0] din_o,
    output logic [NPORT-1:0] din_oe,
    input  logic [NPORT-1:0] dout_i,
    output logic [NPORT-1:0] dout_o,
    output logic [NPORT-1:0] dout_oe
);
    port_cfg_t        cfg_q [NPORT];
    logic [NPORT-1:0] contrib;

    audio_route_cfg #(.NPORT(NPORT), .AW(AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_q     (cfg_q)
    );

    // a swapped port talks on its outbound pin
    always_comb begin
        for (int k = 0; k < NPORT; k++) begin
            contrib[k] = cfg_q[k].swap ? dout_i[k] : din_i[k];
        end
    end

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        audio_route_port #(.NPORT(NPORT), .IS_HOST(k < NHOST)) u_port (
            .cfg      (cfg_q[k]),
            .tck_all  (tck_i),
            .tfs_all  (tfs_i),
            .rck_all  (rck_i),
            .rfs_all  (rfs_i),
            .data_all (contrib),
            .tck_o    (tck_o[k]),
            .tck_oe   (tck_oe[k]),
            .tfs_o    (tfs_o[k]),
            .tfs_oe   (tfs_oe[k]),
            .rck_o    (rck_o[k]),
            .rck_oe   (rck_oe[k]),
            .rfs_o    (rfs_o[k]),
            .rfs_oe   (rfs_oe[k]),
            .din_o    (din_o[k]),
            .din_oe   (din_oe[k]),
            .dout_o   (dout_o[k]),
            .dout_oe  (dout_oe[k])
        );
    end
endmodule

// File: rtl/audio_route_matrix_chk.sv
module audio_route_matrix_chk
    import audio_route_pkg::*;
#(
    parameter int NPORT = 6,
    parameter int AW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [AW-1:0]    cfg_addr,
    input logic [BUS_W-1:0] cfg_wdata,
    input logic [BUS_W-1:0] cfg_rdata,
    input logic [NPORT-1:0] tck_o,
    input logic [NPORT-1:0] tck_oe,
    input logic [NPORT-1:0] tfs_o,
    input logic [NPORT-1:0] tfs_oe,
    input logic [NPORT-1:0] rck_o,
    input logic [NPORT-1:0] rck_oe,
    input logic [NPORT-1:0] rfs_o,
    input logic [NPORT-1:0] rfs_oe,
    input logic [NPORT-1:0] din_oe,
    input logic [NPORT-1:0] dout_o,
    input logic [NPORT-1:0] dout_oe,
    input port_cfg_t        cfg_q [NPORT]
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rdata == '0 && tck_oe == '0 && rck_oe == '0));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && cfg_addr == $past(cfg_addr)
         && (32'(cfg_addr) < NPORT))
        |-> cfg_rdata == {{(BUS_W-CFG_W){1'b0}}, $past(cfg_wdata[CFG_W-1:0])});

    p_data_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((din_oe & dout_oe) == '0) && ((din_oe | dout_oe) == '1));

    for (genvar k = 0; k < NPORT; k++) begin : g_chk
        p_clk_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (tck_oe[k] == cfg_q[k].tck_out) && (tfs_oe[k] == cfg_q[k].tfs_out));

        p_quiet_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!tck_oe[k] |-> !tck_o[k]) and (!tfs_oe[k] |-> !tfs_o[k]));

        p_shared_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[k].sync |-> (rck_o[k] == tck_o[k] && rck_oe[k] == tck_oe[k]
                               && rfs_o[k] == tfs_o[k] && rfs_oe[k] == tfs_oe[k]));

        p_swap_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[k].swap |-> (din_oe[k] && !dout_oe[k] && !dout_o[k]));
    end
endmodule

bind audio_route_matrix audio_route_matrix_chk #(.NPORT(NPORT), .AW(AW)) u_chk (.*);

// File: tb/audio_route_matrix_test.sv
module audio_route_matrix_test;
    localparam int NP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [NP-1:0] tck_i = '0, tfs_i = '0, rck_i = '0, rfs_i = '0, din_i = '0, dout_i = '0;
    logic [NP-1:0] tck_o, tck_oe, tfs_o, tfs_oe, rck_o, rck_oe, rfs_o, rfs_oe;
    logic [NP-1:0] din_o, din_oe, dout_o, dout_oe;

    int    checks = 0, fails = 0, cycles = 0;
    bit    run_chk = 1'b0;
    string cur_req = "R1";
    int    mcfg [NP];

    always #10 clk = ~clk;

    audio_route_matrix uut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic pick(input logic [NP-1:0] v, input int s);
        return (s < NP) ? v[s] : 1'b1;
    endfunction

    function automatic int mk(int tsel, int tck, int tfs, int rsel, int rck, int rfs,
                              int dsel, int sync, int swap, int net, int mask);
        return tsel | (tck << 3) | (tfs << 4) | (rsel << 5) | (rck << 8) | (rfs << 9)
             | (dsel << 10) | (sync << 13) | (swap << 14) | (net << 15) | (mask << 16);
    endfunction

    // behavioural reference of every output
    function automatic logic [127:0] model();
        logic [NP-1:0] c_tx, e_tck, e_tcke, e_tfs, e_tfse, e_rck, e_rcke, e_rfs, e_rfse;
        logic [NP-1:0] e_di, e_die, e_do, e_doe;
        logic r;
        int   rd;
        for (int j = 0; j < NP; j++) c_tx[j] = ((mcfg[j] >> 14) & 1) != 0 ? dout_i[j] : din_i[j];
        for (int k = 0; k < NP; k++) begin
            int c = mcfg[k];
            int ts = c & 7, rs = (c >> 5) & 7, ds = (c >> 10) & 7, mask = (c >> 16) & 255;
            bit to = ((c >> 3) & 1) != 0, fo = ((c >> 4) & 1) != 0;
            bit ro = ((c >> 8) & 1) != 0, qo = ((c >> 9) & 1) != 0;
            bit sy = ((c >> 13) & 1) != 0, sw = ((c >> 14) & 1) != 0, nt = ((c >> 15) & 1) != 0;
            e_tcke[k] = to; e_tck[k] = to ? pick(tck_i, ts) : 1'b0;
            e_tfse[k] = fo; e_tfs[k] = fo ? pick(tfs_i, ts) : 1'b0;
            if (sy) begin
                e_rcke[k] = e_tcke[k]; e_rck[k] = e_tck[k];
                e_rfse[k] = e_tfse[k]; e_rfs[k] = e_tfs[k];
            end else begin
                e_rcke[k] = ro; e_rck[k] = ro ? pick(rck_i, rs) : 1'b0;
                e_rfse[k] = qo; e_rfs[k] = qo ? pick(rfs_i, rs) : 1'b0;
            end
            if (k < 3 && nt) begin
                r = 1'b1;
                for (int j = 0; j < NP; j++) if (((mask >> j) & 1) == 0) r = r & c_tx[j];
            end else begin
                r = pick(c_tx, ds);
            end
            e_die[k] = sw;  e_di[k] = sw ? r : 1'b0;
            e_doe[k] = !sw; e_do[k] = sw ? 1'b0 : r;
        end
        rd = (int'(cfg_addr) < NP) ? mcfg[cfg_addr] : 0;
        return {24'h0, 32'(rd), e_tck, e_tcke, e_tfs, e_tfse, e_rck, e_rcke, e_rfs, e_rfse,
                e_di, e_die, e_do, e_doe};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) mcfg[i] = 0;
        end else if (cfg_we && int'(cfg_addr) < NP) begin
            mcfg[cfg_addr] = cfg_wdata & 32'h00FF_FFFF;
        end
    end

    always @(negedge clk) begin
        if (run_chk) begin
            logic [127:0] act, exp;
            act = {24'h0, cfg_rdata, tck_o, tck_oe, tfs_o, tfs_oe, rck_o, rck_oe, rfs_o, rfs_oe,
                   din_o, din_oe, dout_o, dout_oe};
            exp = model();
            chk(act == exp, cur_req, act, exp);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic rnd_pins();
        tck_i = 6'($urandom); tfs_i = 6'($urandom); rck_i = 6'($urandom);
        rfs_i = 6'($urandom); din_i = 6'($urandom); dout_i = 6'($urandom);
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; rnd_pins(); end
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    initial begin
        @(posedge clk); run_chk = 1'b1;
        idle(2);
        @(posedge clk); #2; rst_n = 1'b1;
        // R1: reset values at the ports
        for (int a = 0; a < 8; a++) begin
            cfg_addr = 3'(a); #1;
            chk(cfg_rdata == 0, "R1", 128'(cfg_rdata), 0);
        end
        chk(dout_oe == '1 && tck_oe == '0 && rfs_oe == '0, "R1", 128'({dout_oe, tck_oe, rfs_oe}), 128'({6'h3F, 12'h0}));
        din_i[0] = 1'b1; #1;
        chk(dout_o == '1, "R1", 128'(dout_o), 128'(6'h3F));
        din_i[0] = 1'b0; #1;
        chk(dout_o == '0, "R1", 128'(dout_o), 0);
        idle(3);

        // R2: write lands on the next edge, upper bits dropped
        cur_req = "R2";
        cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        chk(cfg_rdata == 0, "R2", 128'(cfg_rdata), 0);
        @(posedge clk); #2; cfg_we = 1'b0;
        @(negedge clk);
        chk(cfg_rdata == 32'h00FF_FFFF, "R2", 128'(cfg_rdata), 128'(32'h00FF_FFFF));
        @(posedge clk); #2;
        wr(6, 32'h00FF_FFFF);
        cfg_addr = 3'd6; #1;
        chk(cfg_rdata == 0, "R2", 128'(cfg_rdata), 0);
        wr(2, 0);
        idle(2);

        cur_req = "R3";
        wr(0, mk(4, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(3, mk(6, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr(5, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        idle(6);
        chk(tck_o[3] == 1'b1 && tfs_oe[3] == 1'b0, "R3", 128'({tck_o[3], tfs_oe[3]}), 128'(2'b10));

        cur_req = "R5";
        wr(0, mk(4, 1, 1, 5, 1, 1, 4, 0, 0, 0, 0));
        wr(1, mk(1, 1, 0, 7, 1, 0, 0, 0, 0, 0, 0));
        idle(6);

        cur_req = "R4";
        wr(0, mk(4, 1, 1, 5, 1, 1, 4, 1, 0, 0, 0));
        wr(1, mk(1, 0, 1, 3, 1, 1, 0, 1, 0, 0, 0));
        idle(6);

        cur_req = "R6";
        for (int s = 0; s < 8; s++) begin
            wr(2, mk(0, 0, 0, 0, 0, 0, s, 0, 0, 0, 0));
            idle(2);
        end
        chk(dout_o[2] == 1'b1, "R6", 128'(dout_o[2]), 1);

        cur_req = "R7";
        wr(4, mk(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0));
        wr(1, mk(0, 0, 0, 0, 0, 0, 4, 0, 0, 0, 0));
        idle(6);
        dout_i[4] = 1'b1; din_i[4] = 1'b0; #1;
        chk(dout_o[1] == 1'b1 && dout_oe[4] == 1'b0, "R7", 128'({dout_o[1], dout_oe[4]}), 128'(2'b10));
        wr(4, 0);

        cur_req = "R8";
        wr(1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hE7));
        din_i[3] = 1'b1; din_i[4] = 1'b0; #1;
        chk(dout_o[1] == 1'b0, "R8", 128'(dout_o[1]), 0);
        din_i[4] = 1'b1; #1;
        chk(dout_o[1] == 1'b1, "R8", 128'(dout_o[1]), 1);
        idle(4);
        wr(1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h3F));
        din_i = '0; #1;
        chk(dout_o[1] == 1'b1, "R8", 128'(dout_o[1]), 1);
        idle(3);
        wr(1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00));
        din_i = '1; #1;
        chk(dout_o[1] == 1'b1, "R8", 128'(dout_o[1]), 1);
        din_i[5] = 1'b0; #1;
        chk(dout_o[1] == 1'b0, "R8", 128'(dout_o[1]), 0);
        idle(4);

        cur_req = "R9";
        wr(4, mk(0, 0, 0, 0, 0, 0, 2, 0, 0, 1, 8'h00));
        wr(1, mk(0, 0, 0, 0, 0, 0, 5, 0, 0, 0, 8'hE7));
        din_i = 6'b011111; #1;
        chk(dout_o[4] == 1'b1 && dout_o[1] == 1'b0, "R9", 128'({dout_o[4], dout_o[1]}), 128'(2'b10));
        idle(5);

        cur_req = "R10";
        wr(0, mk(3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        tck_i[3] = 1'b1; #1;
        chk(tck_o[0] == 1'b1, "R10", 128'(tck_o[0]), 1);
        tck_i[3] = 1'b0; #1;
        chk(tck_o[0] == 1'b0, "R10", 128'(tck_o[0]), 0);
        idle(3);

        run_chk = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule